// File: doc/BRIEF.md
# Home-Node Cache Directory Controller

This block is the coherence directory at the home node of a small distributed-memory multiprocessor. For each memory block it tracks a coherence state (Uncached, Shared or Exclusive) and a sharer vector with one bit per processor. In Exclusive, the single set bit names the owner. The block also holds the home copy of each block's data.

It takes one request at a time. A request is a read miss, a write miss or a data write-back, and it names a processor and a block. The block answers with outgoing messages on a single message port, at most one per cycle. The messages are data replies, invalidates, fetches and fetch-invalidates to an owner, and write-back acknowledgements. When the block asks an owner for data, it stalls new requests until the owner's data comes back on the response port. It then writes that data to the home copy and forwards it to the requester.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is Uncached with no sharers and a home copy of zero, req_ready is 1 and msg_valid is 0.
- R2: A read miss (req_type 0) on an Uncached block sends a data reply (msg_type 0) with the home copy to the requester, and leaves the block Shared with only the requester as sharer.
- R3: A write miss (req_type 1) on an Uncached block sends a data reply with the home copy to the requester, and leaves the block Exclusive with the requester as owner.
- R4: A read miss on a Shared block sends a data reply with the home copy and adds the requester to the sharers. The block stays Shared.
- R5: A write miss on a Shared block sends one invalidate (msg_type 1) per cycle to every sharer other than the requester, in ascending processor order. The cycle after the last invalidate, it sends the data reply. The block ends Exclusive with the requester as owner.
- R6: A read miss on an Exclusive block sends a fetch (msg_type 2) to the owner. When the owner's data arrives, it is written to the home copy and forwarded in a data reply to the requester. The block becomes Shared with both the old owner and the requester as sharers.
- R7: A write miss on an Exclusive block sends a fetch-invalidate (msg_type 3) to the owner. The returned data is forwarded to the requester, which becomes the sole owner, and the block stays Exclusive.
- R8: A data write-back (req_type 2) from the owner of an Exclusive block writes req_data to the home copy, sends an acknowledgement (msg_type 4) to the writer, and leaves the block Uncached with no sharers.
- R9: While invalidates are pending or owner data is awaited, req_ready is 0 and a held request waits. It is taken only after the transaction in progress has sent its reply.
- R10: A write-back from a processor that is not the owner, or a request of type 3, is acknowledged with msg_type 4 and changes neither state, sharers nor data.
- R11: An owner response arriving while no owner data is awaited is ignored: it produces no message and leaves the home copy unchanged.
- R12: Every accepted request produces a message in the cycle after it is accepted, and msg_addr carries the request's block address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 reserved |
| req_proc | input | $clog2(N) | Requesting processor |
| req_addr | input | $clog2(BLOCKS) | Block address |
| req_data | input | DW | Write-back data |
| rsp_valid | input | 1 | Owner data response present |
| rsp_data | input | DW | Owner data |
| msg_valid | output | 1 | Outgoing message present |
| msg_type | output | 3 | 0 reply, 1 invalidate, 2 fetch, 3 fetch-invalidate, 4 acknowledge |
| msg_dest | output | $clog2(N) | Destination processor |
| msg_addr | output | $clog2(BLOCKS) | Block address |
| msg_data | output | DW | Data for replies, else zero |

## Verification
Two events can fall in the same cycle: the owner's data response, which ends a fetch, and a new request that is already being held on the request port. The bench holds a read miss on the port through a whole fetch wait. It checks that req_ready stays low and that only the fetch has been sent. It then returns owner data and checks two replies on consecutive cycles: first to the original requester, then to the held requester. The held requester must get the freshly written data straight from the home copy, with no second fetch. An owner response sent while the controller is idle is also checked to produce nothing.

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int N = 8,
  parameter int BLOCKS = 16,
  parameter int DW = 16,
  localparam int PW = $clog2(N),
  localparam int AW = $clog2(BLOCKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_type,
  input  logic [PW-1:0] req_proc,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          msg_valid,
  output logic [2:0]    msg_type,
  output logic [PW-1:0] msg_dest,
  output logic [AW-1:0] msg_addr,
  output logic [DW-1:0] msg_data
);
  typedef enum logic [1:0] {UNC, SHR, EXC} blk_t;
  typedef enum logic [1:0] {IDLE, INVS, WAIT} fsm_t;
  localparam logic [2:0] M_REPLY = 3'd0, M_INV = 3'd1, M_FETCH = 3'd2, M_FINV = 3'd3, M_ACK = 3'd4;

  blk_t          st  [BLOCKS];
  logic [N-1:0]  shr [BLOCKS];
  logic [DW-1:0] mem [BLOCKS];
  fsm_t          fsm;
  logic [PW-1:0] cur_proc;
  logic [AW-1:0] cur_addr;
  logic          cur_wr;
  logic [N-1:0]  pend;

  function automatic logic [PW-1:0] low_idx(input logic [N-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = PW'(i);
    return r;
  endfunction

  assign req_ready = (fsm == IDLE);

  wire           accept  = req_valid && req_ready;
  blk_t          cst;
  logic [N-1:0]  csh, rbit, cbit, invmask;
  logic [PW-1:0] owner, lo_acc, lo_pend;
  always_comb begin
    cst     = st[req_addr];
    csh     = shr[req_addr];
    rbit    = N'(1) << req_proc;
    cbit    = N'(1) << cur_proc;
    invmask = csh & ~rbit;
    owner   = low_idx(csh);
    lo_acc  = low_idx(invmask);
    lo_pend = low_idx(pend);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm       <= IDLE;
      msg_valid <= 1'b0;
      msg_type  <= '0;
      msg_dest  <= '0;
      msg_addr  <= '0;
      msg_data  <= '0;
      cur_proc  <= '0;
      cur_addr  <= '0;
      cur_wr    <= 1'b0;
      pend      <= '0;
      for (int b = 0; b < BLOCKS; b++) begin
        st[b]  <= UNC;
        shr[b] <= '0;
        mem[b] <= '0;
      end
    end else begin
      msg_valid <= 1'b0;
      msg_data  <= '0;
      case (fsm)
        IDLE: if (accept) begin
          cur_proc  <= req_proc;
          cur_addr  <= req_addr;
          cur_wr    <= (req_type == 2'd1);
          msg_valid <= 1'b1;
          msg_addr  <= req_addr;
          case (req_type)
            2'd0: if (cst == EXC) begin
              msg_type <= M_FETCH;
              msg_dest <= owner;
              fsm      <= WAIT;
            end else begin
              msg_type      <= M_REPLY;
              msg_dest      <= req_proc;
              msg_data      <= mem[req_addr];
              st[req_addr]  <= SHR;
              shr[req_addr] <= ((cst == SHR) ? csh : '0) | rbit;
            end
            2'd1: if (cst == EXC) begin
              msg_type <= M_FINV;
              msg_dest <= owner;
              fsm      <= WAIT;
            end else begin
              st[req_addr]  <= EXC;
              shr[req_addr] <= rbit;
              if (cst == SHR && invmask != '0) begin
                msg_type <= M_INV;
                msg_dest <= lo_acc;
                pend     <= invmask & ~(N'(1) << lo_acc);
                fsm      <= INVS;
              end else begin
                msg_type <= M_REPLY;
                msg_dest <= req_proc;
                msg_data <= mem[req_addr];
              end
            end
            2'd2: begin
              msg_type <= M_ACK;
              msg_dest <= req_proc;
              if (cst == EXC && csh == rbit) begin
                mem[req_addr] <= req_data;
                st[req_addr]  <= UNC;
                shr[req_addr] <= '0;
              end
            end
            default: begin
              msg_type <= M_ACK;
              msg_dest <= req_proc;
            end
          endcase
        end
        INVS: begin
          msg_valid <= 1'b1;
          msg_addr  <= cur_addr;
          if (pend != '0) begin
            msg_type <= M_INV;
            msg_dest <= lo_pend;
            pend     <= pend & ~(N'(1) << lo_pend);
          end else begin
            msg_type <= M_REPLY;
            msg_dest <= cur_proc;
            msg_data <= mem[cur_addr];
            fsm      <= IDLE;
          end
        end
        WAIT: if (rsp_valid) begin
          mem[cur_addr] <= rsp_data;
          msg_valid     <= 1'b1;
          msg_type      <= M_REPLY;
          msg_dest      <= cur_proc;
          msg_addr      <= cur_addr;
          msg_data      <= rsp_data;
          if (cur_wr) shr[cur_addr] <= cbit;
          else begin
            st[cur_addr]  <= SHR;
            shr[cur_addr] <= shr[cur_addr] | cbit;
          end
          fsm <= IDLE;
        end
        default: fsm <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(parameter int PW = 3) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          msg_valid,
  input logic [2:0]    msg_type,
  input logic [PW-1:0] msg_dest
);
  a_r12_accept_answers: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> msg_valid);

  a_r9_busy_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && (msg_type == 3'd2 || msg_type == 3'd3) |-> !req_ready);

  a_r5_busy_on_inv: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_type == 3'd1 |-> !req_ready);

  a_r5_inv_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_type == 3'd1 && $past(msg_valid && msg_type == 3'd1)
    |-> msg_dest > $past(msg_dest));

  a_r11_msg_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(req_valid && req_ready) || $past(!req_ready));
endmodule

bind dir_home_ctrl dir_home_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .msg_valid(msg_valid), .msg_type(msg_type), .msg_dest(msg_dest)
);

// File: tb/tb_dir_home_ctrl.sv
module tb_dir_home_ctrl;
  localparam int N = 8, B = 16, DW = 16, PW = 3, AW = 4;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rsp_valid = 0;
  logic req_ready, msg_valid;
  logic [1:0] req_type = 0;
  logic [PW-1:0] req_proc = 0, msg_dest;
  logic [AW-1:0] req_addr = 0, msg_addr;
  logic [DW-1:0] req_data = 0, rsp_data = 0, msg_data;
  logic [2:0] msg_type;

  dir_home_ctrl #(.N(N), .BLOCKS(B), .DW(DW)) dut (.*);

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int lt[64], ld[64], la[64], lx[64], lc[64];
  int ln = 0;
  always @(negedge clk) if (rst_n && msg_valid && ln < 64) begin
    lt[ln] = msg_type; ld[ln] = msg_dest; la[ln] = msg_addr; lx[ln] = msg_data; lc[ln] = cyc;
    ln++;
  end

  int checks = 0, fails = 0;
  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic chkmsg(input string tag, input int i, input int t, input int d, input int x);
    chk({tag, " msg present"}, int'(ln > i), 1);
    if (ln > i) begin
      chk({tag, " type"}, lt[i], t);
      chk({tag, " dest"}, ld[i], d);
      chk({tag, " data"}, lx[i], x);
    end
  endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask
  task automatic clr(); ln = 0; endtask

  task automatic req(input int t, input int p, input int a, input int d);
    @(negedge clk);
    req_valid = 1; req_type = 2'(t); req_proc = PW'(p); req_addr = AW'(a); req_data = DW'(d);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic owner(input int d);
    @(negedge clk); rsp_valid = 1; rsp_data = DW'(d);
    @(negedge clk); rsp_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 no msg after reset", msg_valid, 0);
  endtask

  task automatic t_read_shared();
    clr(); req(0, 2, 3, 0); idle(2);
    chkmsg("R2 read uncached", 0, 0, 2, 0);
    chk("R12 addr", la[0], 3);
    chk("R1 single msg", ln, 1);
    clr(); req(0, 5, 3, 0); req(0, 0, 3, 0); idle(2);
    chkmsg("R4 read shared p5", 0, 0, 5, 0);
    chkmsg("R4 read shared p0", 1, 0, 0, 0);
  endtask

  task automatic t_write_shared();
    clr(); req(1, 5, 3, 0); idle(6);
    chk("R5 msg count", ln, 3);
    chkmsg("R5 inv p0", 0, 1, 0, 0);
    chkmsg("R5 inv p2", 1, 1, 2, 0);
    chkmsg("R5 reply", 2, 0, 5, 0);
    chk("R5 per cycle", lc[1] - lc[0], 1);
    chk("R5 reply next", lc[2] - lc[1], 1);
  endtask

  task automatic t_write_excl();
    clr(); req(1, 1, 3, 0); idle(2);
    chkmsg("R7 fetch-inv", 0, 3, 5, 0);
    chk("R9 ready low fetch-inv", req_ready, 0);
    owner(16'hBEEF); idle(1);
    chkmsg("R7 forward", 1, 0, 1, 16'hBEEF);
    chk("R7 count", ln, 2);
  endtask

  task automatic t_read_excl();
    clr(); req(0, 4, 3, 0); idle(2);
    chkmsg("R6 fetch", 0, 2, 1, 0);
    owner(16'h1234); idle(1);
    chkmsg("R6 forward", 1, 0, 4, 16'h1234);
    clr(); req(1, 6, 3, 0); idle(6);
    chkmsg("R6 inv old owner", 0, 1, 1, 0);
    chkmsg("R6 inv reader", 1, 1, 4, 0);
    chkmsg("R6 home copy written", 2, 0, 6, 16'h1234);
  endtask

  task automatic t_wb_nonowner();
    clr(); req(2, 2, 3, 16'h5555); idle(2);
    chkmsg("R10 ack non-owner", 0, 4, 2, 0);
    clr(); req(0, 3, 3, 0); idle(2);
    chkmsg("R10 still exclusive", 0, 2, 6, 0);
    owner(16'h7777); idle(1);
    chkmsg("R10 data kept", 1, 0, 3, 16'h7777);
    clr(); req(3, 4, 3, 0); idle(2);
    chkmsg("R10 type3 ack", 0, 4, 4, 0);
    clr(); req(0, 5, 3, 0); idle(2);
    chkmsg("R10 type3 no change", 0, 0, 5, 16'h7777);
  endtask

  task automatic t_writeback();
    clr(); req(1, 3, 9, 0); idle(2);
    chkmsg("R3 write uncached", 0, 0, 3, 0);
    clr(); req(2, 3, 9, 16'hA5A5); idle(2);
    chkmsg("R8 ack", 0, 4, 3, 0);
    clr(); req(0, 0, 9, 0); idle(2);
    chkmsg("R8 uncached with data", 0, 0, 0, 16'hA5A5);
    clr(); req(1, 1, 9, 0); idle(4);
    chk("R8 sharers cleared count", ln, 2);
    chkmsg("R8 inv only p0", 0, 1, 0, 0);
    chkmsg("R8 reply", 1, 0, 1, 16'hA5A5);
  endtask

  task automatic t_overlap();
    clr(); req(1, 1, 12, 0); idle(2);
    chkmsg("R3 reply", 0, 0, 1, 0);
    clr(); req(0, 2, 12, 0);
    @(negedge clk);
    req_valid = 1; req_type = 2'd0; req_proc = 3'd7; req_addr = 4'd12;
    idle(3);
    chk("R9 ready low during wait", req_ready, 0);
    chk("R9 held request not taken", ln, 1);
    chkmsg("R3 fetch to owner", 0, 2, 1, 0);
    owner(16'h4242);
    @(negedge clk); req_valid = 0;
    idle(2);
    chk("R9 msg count", ln, 3);
    chkmsg("R9 first reply", 1, 0, 2, 16'h4242);
    chkmsg("R9 held reply", 2, 0, 7, 16'h4242);
    chk("R9 held reply next cycle", lc[2] - lc[1], 1);
  endtask

  task automatic t_stray_rsp();
    clr(); owner(16'h9999); idle(2);
    chk("R11 no msg on stray rsp", ln, 0);
    clr(); req(0, 0, 12, 0); idle(2);
    chkmsg("R11 data unchanged", 0, 0, 0, 16'h4242);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    idle(3); rst_n = 1; idle(1);
    t_reset();
    t_read_shared();
    t_write_shared();
    t_write_excl();
    t_read_excl();
    t_wb_nonowner();
    t_writeback();
    t_overlap();
    t_stray_rsp();
    idle(2);
    finish_run();
  end

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    finish_run();
  end
endmodule